// File: doc/BRIEF.md
# Digital Potentiometer Wiper Controller

This block keeps the code that positions a potentiometer wiper and turns it into the switch controls for a resistor ladder. A serial front end hands it new codes through a write channel, a midscale command and a shutdown level. The stored code drives a one-hot vector that closes exactly one of the ladder's tap switches. Code 0 is the tap at the B end of the ladder, and each step up moves the wiper one tap toward the A end. Two further controls put the wiper into its shutdown state: one opens terminal A and the other ties the wiper to terminal B.

Shutdown and the midscale command behave differently. Shutdown never changes the stored code and still accepts writes, so the newest code drives the ladder once shutdown ends. The midscale command overwrites the stored code with the half-scale value. The stored code can be read back at all times. Tap changes are break-before-make: every switch is open for one cycle between the old tap and the new one.

The write channel is valid/ready. `wr_ready` is held high, so the block never applies back-pressure. A write is taken on every clock edge where `wr_valid` is high. The front end may hold `wr_valid` high for several cycles, and each such edge loads `wr_data` again.

Top module: `wiper_ctrl`

## Requirements
- R1: While `rst_n` is low and after it rises, the stored code is 0x80 (midscale), only tap bit 128 is set, and both terminal controls are low.
- R2: A write accepted at a clock edge with `mid_rst` low appears on `code_o` after that edge. `wr_ready` is always 1.
- R3: `mid_rst` high at an edge loads 0x80. The code stays 0x80 after `mid_rst` drops, until the next write.
- R4: When `mid_rst` and an accepted write meet at the same edge, the stored code becomes 0x80 and the write data is discarded.
- R5: Outside shutdown, once settled, `tap_sel_o` has exactly one bit set, at index `code_o`. Bit 0 is the B end of the ladder.
- R6: `tap_sel_o` never has more than one bit set. When the selected tap changes, the vector is all zero for exactly one cycle and then shows the new tap.
- R7: `a_open_o` and `w_to_b_o` go high one cycle after `shdn_en` is sampled high, and go low one cycle after it is sampled low.
- R8: Shutdown leaves `code_o` unchanged, and while it lasts the settled tap vector selects only bit 0.
- R9: Writes taken during shutdown update `code_o` at once. That code drives the taps when shutdown ends.
- R10: An edge with `wr_valid` and `mid_rst` both low leaves the stored code unchanged, whatever is on `wr_data`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_valid | input | 1 | Write request for a new wiper code |
| wr_ready | output | 1 | Always high; the block never stalls a write |
| wr_data | input | 8 | New wiper code |
| mid_rst | input | 1 | Load midscale (0x80) into the code |
| shdn_en | input | 1 | Shutdown level |
| code_o | output | 8 | Stored code for readback |
| tap_sel_o | output | 256 | One-hot tap switch closes, bit 0 at the B end |
| a_open_o | output | 1 | Opens terminal A |
| w_to_b_o | output | 1 | Shorts the wiper to terminal B |

## Verification
The codes are tried at both ends of the range (0x00 and 0xFF), at the first step above the B end, at midscale, and at arbitrary mid-range values. This shows whether the tap index follows the code and whether it runs in the right direction. A midscale command is sent on its own and together with a conflicting write, which tests its priority over writes. Shutdown is entered with no traffic and then with a write during it, which separates an untouched stored code from one updated while the ladder is parked. Cycle-exact samples around a code change and around shutdown entry and exit check the one-cycle break and the register delay of the terminal controls.

// File: rtl/wpr_pkg.sv
package wpr_pkg;
  localparam int unsigned WPR_CODE_W = 8;

  function automatic logic [WPR_CODE_W-1:0] wpr_mid_code();
    logic [WPR_CODE_W-1:0] m;
    m = '0;
    m[WPR_CODE_W-1] = 1'b1;
    return m;
  endfunction
endpackage

// File: rtl/wpr_code_reg.sv
module wpr_code_reg #(
  parameter int unsigned CODE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_fire,
  input  logic [CODE_W-1:0] wr_data,
  input  logic              mid_rst,
  output logic [CODE_W-1:0] code_q
);
  localparam logic [CODE_W-1:0] MID = {1'b1, {(CODE_W-1){1'b0}}};

  // midscale command wins over a write at the same edge
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       code_q <= MID;
    else if (mid_rst) code_q <= MID;
    else if (wr_fire) code_q <= wr_data;
  end

  assert_mid_prio_R4: assert property (@(posedge clk) disable iff (!rst_n)
    mid_rst |=> (code_q == MID));
  assert_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_fire && !mid_rst) |=> (code_q == $past(wr_data)));
  assert_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_fire && !mid_rst) |=> $stable(code_q));
endmodule

// File: rtl/wpr_term_ctrl.sv
module wpr_term_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic shdn_en,
  output logic shdn_q,
  output logic a_open,
  output logic w_to_b
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) shdn_q <= 1'b0;
    else        shdn_q <= shdn_en;
  end

  assign a_open = shdn_q;
  assign w_to_b = shdn_q;

  assert_enter_R7: assert property (@(posedge clk) disable iff (!rst_n)
    shdn_en |=> (a_open && w_to_b));
  assert_leave_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !shdn_en |=> (!a_open && !w_to_b));
endmodule

// File: rtl/wpr_tap_drive.sv
module wpr_tap_drive #(
  parameter int unsigned CODE_W = 8,
  localparam int unsigned NTAPS = 1 << CODE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CODE_W-1:0] code,
  input  logic              park,
  output logic [NTAPS-1:0]  tap_q
);
  localparam logic [NTAPS-1:0] ONE = NTAPS'(1);
  localparam logic [NTAPS-1:0] RST_TAP = ONE << (NTAPS / 2);

  logic [CODE_W-1:0] sel_idx;
  logic [NTAPS-1:0]  target;
  logic              moving;

  // shutdown parks the wiper on the B-end tap
  assign sel_idx = park ? '0 : code;
  assign target  = ONE << sel_idx;
  assign moving  = (tap_q != '0) && (tap_q != target);

  // break-before-make: open all, then close the new tap
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          tap_q <= RST_TAP;
    else if (moving)     tap_q <= '0;
    else if (tap_q == '0) tap_q <= target;
  end

  assert_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(tap_q));
  assert_break_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (tap_q != '0) |=> (tap_q == '0 || tap_q == $past(tap_q)));
  assert_gap_one_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (tap_q == '0) |=> (tap_q != '0));
  assert_park_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (park && $past(park) && tap_q != '0 && $past(tap_q) != '0) |-> tap_q[0]);
endmodule

// File: rtl/wiper_ctrl.sv
module wiper_ctrl #(
  parameter int unsigned CODE_W = wpr_pkg::WPR_CODE_W,
  localparam int unsigned NTAPS = 1 << CODE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_valid,
  output logic              wr_ready,
  input  logic [CODE_W-1:0] wr_data,
  input  logic              mid_rst,
  input  logic              shdn_en,
  output logic [CODE_W-1:0] code_o,
  output logic [NTAPS-1:0]  tap_sel_o,
  output logic              a_open_o,
  output logic              w_to_b_o
);
  logic shdn_q;
  logic wr_fire;

  assign wr_ready = 1'b1;
  assign wr_fire  = wr_valid && wr_ready;

  wpr_code_reg #(.CODE_W(CODE_W)) u_code (
    .clk(clk), .rst_n(rst_n), .wr_fire(wr_fire), .wr_data(wr_data),
    .mid_rst(mid_rst), .code_q(code_o)
  );

  wpr_term_ctrl u_term (
    .clk(clk), .rst_n(rst_n), .shdn_en(shdn_en), .shdn_q(shdn_q),
    .a_open(a_open_o), .w_to_b(w_to_b_o)
  );

  wpr_tap_drive #(.CODE_W(CODE_W)) u_tap (
    .clk(clk), .rst_n(rst_n), .code(code_o), .park(shdn_q), .tap_q(tap_sel_o)
  );

  assert_shdn_code_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (shdn_q && !wr_fire && !mid_rst) |=> $stable(code_o));
endmodule

// File: tb/test_wiper_ctrl.sv
module test_wiper_ctrl;
  localparam time CLK_PERIOD = 10ns;
  localparam int  NV = 10;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         wr_valid = 1'b0;
  logic         wr_ready;
  logic [7:0]   wr_data = '0;
  logic         mid_rst = 1'b0;
  logic         shdn_en = 1'b0;
  logic [7:0]   code_o;
  logic [255:0] tap_sel_o;
  logic         a_open_o;
  logic         w_to_b_o;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  wiper_ctrl i_wiper_ctrl (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .wr_data(wr_data), .mid_rst(mid_rst), .shdn_en(shdn_en), .code_o(code_o),
    .tap_sel_o(tap_sel_o), .a_open_o(a_open_o), .w_to_b_o(w_to_b_o)
  );

  // row: {exp_tap, exp_code, data, shdn, mid, valid}
  localparam logic [26:0] VEC [NV] = '{
    {8'd0,   8'd0,   8'h00, 1'b0, 1'b0, 1'b1},  // R2 R5 B end
    {8'd255, 8'd255, 8'hFF, 1'b0, 1'b0, 1'b1},  // R2 R5 A end
    {8'd1,   8'd1,   8'h01, 1'b0, 1'b0, 1'b1},  // R5 first step
    {8'd128, 8'd128, 8'h00, 1'b0, 1'b1, 1'b0},  // R3 midscale
    {8'd128, 8'd128, 8'h37, 1'b0, 1'b1, 1'b1},  // R4 priority
    {8'd0,   8'd128, 8'h00, 1'b1, 1'b0, 1'b0},  // R8 shutdown
    {8'd0,   8'd68,  8'h44, 1'b1, 1'b0, 1'b1},  // R9 write in shutdown
    {8'd68,  8'd68,  8'h00, 1'b0, 1'b0, 1'b0},  // R9 exit applies
    {8'd200, 8'd200, 8'hC8, 1'b0, 1'b0, 1'b1},  // R5 mid-range
    {8'd200, 8'd200, 8'h11, 1'b0, 1'b0, 1'b0}   // R10 no valid
  };

  function automatic int tap_index(input logic [255:0] v);
    int idx = -1;
    int cnt = 0;
    for (int i = 0; i < 256; i++) if (v[i]) begin idx = i; cnt++; end
    return (cnt == 1) ? idx : -1 - cnt;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 100000) begin
        checks++;
        errors++;
        $display("FAIL watchdog: actual %0d expected %0d", cycles, 100000);
        finish_run();
      end
    end
  end

  initial begin
    tick(2);
    // R1 during reset
    check(code_o == 8'h80, "R1 code in reset", code_o, 128);
    check(tap_index(tap_sel_o) == 128, "R1 tap in reset", tap_index(tap_sel_o), 128);
    rst_n = 1'b1;
    tick(2);
    check(code_o == 8'h80, "R1 code after reset", code_o, 128);
    check(tap_index(tap_sel_o) == 128, "R1 tap after reset", tap_index(tap_sel_o), 128);
    check(!a_open_o && !w_to_b_o, "R1 terminals", {a_open_o, w_to_b_o}, 0);
    check(wr_ready == 1'b1, "R2 ready", wr_ready, 1);

    for (int r = 0; r < NV; r++) begin
      wr_valid = VEC[r][0];
      mid_rst  = VEC[r][1];
      shdn_en  = VEC[r][2];
      wr_data  = VEC[r][10:3];
      tick(1);
      wr_valid = 1'b0;
      mid_rst  = 1'b0;
      wr_data  = 8'h5A;
      tick(4);
      check(code_o == VEC[r][18:11], $sformatf("R2 R3 R4 R10 code row %0d", r),
            code_o, VEC[r][18:11]);
      check(tap_index(tap_sel_o) == int'(VEC[r][26:19]),
            $sformatf("R5 R8 R9 tap row %0d", r), tap_index(tap_sel_o), VEC[r][26:19]);
    end

    // R6 break-before-make timing: 200 -> 17
    wr_valid = 1'b1; wr_data = 8'd17;
    tick(1);
    wr_valid = 1'b0;
    check(code_o == 8'd17, "R2 code next cycle", code_o, 17);
    check(tap_index(tap_sel_o) == 200, "R6 old tap held", tap_index(tap_sel_o), 200);
    tick(1);
    check(tap_sel_o == '0, "R6 gap cycle", tap_index(tap_sel_o), -1);
    tick(1);
    check(tap_index(tap_sel_o) == 17, "R6 new tap", tap_index(tap_sel_o), 17);

    // R7 shutdown entry and exit timing
    shdn_en = 1'b1;
    tick(1);
    check(a_open_o && w_to_b_o, "R7 enter", {a_open_o, w_to_b_o}, 3);
    check(code_o == 8'd17, "R8 code kept", code_o, 17);
    tick(2);
    check(tap_index(tap_sel_o) == 0, "R8 parked", tap_index(tap_sel_o), 0);
    shdn_en = 1'b0;
    tick(1);
    check(!a_open_o && !w_to_b_o, "R7 leave", {a_open_o, w_to_b_o}, 0);
    tick(2);
    check(tap_index(tap_sel_o) == 17, "R8 restored", tap_index(tap_sel_o), 17);

    // R3 midscale held after command drops, then a write replaces it
    mid_rst = 1'b1;
    tick(1);
    mid_rst = 1'b0;
    tick(3);
    check(code_o == 8'h80, "R3 stays midscale", code_o, 128);
    wr_valid = 1'b1; wr_data = 8'hFE;
    tick(1);
    wr_valid = 1'b0;
    check(code_o == 8'hFE, "R2 after midscale", code_o, 254);

    finish_run();
  end
endmodule